// File: doc/BRIEF.md
# Free-Running Timer Counter with Coherent Byte Reads

This block is a free-running up-counter for a processor with an 8-bit data bus. A divide-by-four prescaler runs from the bus clock, and each terminal count of the prescaler advances the counter by one. Software reads the count one byte at a time. The count appears at two byte-pair addresses: a primary pair and an alternate pair. Reading a high byte first freezes the matching low byte in a holding buffer. The two bytes read then always belong to the same count value, even though the counter keeps running between the two accesses.

When the counter wraps from all ones to zero, it raises an overflow flag. The flag drives an interrupt request while the enable input is high. Software clears the flag in two steps. It first reads the status register while the flag is set, which arms the clear. It then accesses the primary counter pair. The alternate pair never takes part in clearing, so a background task can sample time through it without losing an overflow that is still pending.

Two state machines hold the control state. The read buffer machine has two states. RB_LIVE moves to RB_HELD on a high-byte read and captures the live low byte. RB_HELD moves back to RB_LIVE on a low-byte read. The overflow machine has three states. OVF_IDLE moves to OVF_PEND on a wrap. OVF_PEND moves to OVF_ARMED on a status read when no wrap occurs in the same cycle. OVF_ARMED moves to OVF_IDLE on a primary-pair access. A wrap in any state leads to OVF_PEND, and in OVF_ARMED it takes priority over a primary-pair access in the same cycle. The flag is high in OVF_PEND and OVF_ARMED.

Top module: `frc_timer`

## Requirements
- R1: The counter advances by exactly one on every fourth clock edge after reset and holds its value on all other edges.
- R2: Reset loads the counter with 0xFFFC and clears the prescaler, the buffer sequence and the overflow flag. The first increment happens on the fourth clock edge after reset is released.
- R3: Reads at address 0x18 and 0x1A return the counter high byte. Reads at 0x19 and 0x1B return the low byte. A read at any other address returns 0x00 and does not change the buffer sequence.
- R4: A low-byte read (0x19 or 0x1B) with no pending high-byte read returns the live low byte in the cycle of the read.
- R5: A high-byte read (0x18 or 0x1A) copies the live low byte into the holding buffer. Further high-byte reads from either pair leave the buffer unchanged until a low-byte read occurs.
- R6: A low-byte read from either pair after a high-byte read returns the buffered byte and ends the sequence. The next low-byte read returns live data again.
- R7: Reads, status reads and their timing never change the counting sequence.
- R8: The overflow flag is set on the clock edge where the counter wraps from all ones to zero. The interrupt output is high exactly when the flag and the enable input are both 1.
- R9: A status read while the flag is set, followed by a read at 0x18 or 0x19, clears the flag.
- R10: Reads at 0x1A or 0x1B never clear the flag, even after a status read has armed the clear.
- R11: A wrap that occurs after the arming status read and before the primary-pair access leaves the flag set. A new status read is needed before an access can clear it.
- R12: A primary-pair access without a preceding status read while the flag is set leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe for the counter registers |
| rd_addr | input | ADDR_W (8) | Register address of the read |
| stat_rd | input | 1 | High in a cycle in which the status register is read |
| ovf_ie | input | 1 | Overflow interrupt enable |
| rd_data | output | 8 | Read data, valid in the same cycle as rd_en |
| ovf_flag | output | 1 | Timer overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A buffer machine stuck in RB_HELD shows up on the second low-byte read of a pair: it returns a stale byte instead of the live count. A capture taken at the wrong time shows up as a low byte that does not match the count at the moment of the high-byte read. Both errors appear on the first read that follows them. A wrong overflow state shows up in ovf_flag one clock after the access or wrap that should have changed it. A lost OVF_PEND transition on a second wrap is caught by a narrow-counter instance that wraps every 1024 cycles. Because the prescaler phase is fixed from reset, any miscount appears as a wrong byte on the next read.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam logic [7:0] ADR_MAIN_HI = 8'h18;
    localparam logic [7:0] ADR_MAIN_LO = 8'h19;
    localparam logic [7:0] ADR_ALT_HI  = 8'h1A;
    localparam logic [7:0] ADR_ALT_LO  = 8'h1B;

    typedef enum logic {
        RB_LIVE,
        RB_HELD
    } rdbuf_state_t;

    typedef enum logic [1:0] {
        OVF_IDLE,
        OVF_PEND,
        OVF_ARMED
    } ovf_state_t;

endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/frc_count.sv
module frc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RST_VAL  = ALL_ONES ^ CNT_W'(3);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= RST_VAL;
        else if (step)
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;
    assign wrap  = step && (count_q == ALL_ONES);
endmodule

// File: rtl/frc_rdbuf.sv
module frc_rdbuf
    import frc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_rd,
    input  logic       lo_rd,
    input  logic [7:0] live_lo,
    output logic       held,
    output logic [7:0] buf_val
);
    rdbuf_state_t state_q, state_d;
    logic [7:0]   buf_q, buf_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_LIVE;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            buf_q   <= buf_d;
        end
    end

    always_comb begin
        state_d = state_q;
        buf_d   = buf_q;
        unique case (state_q)
            RB_LIVE: begin
                if (hi_rd) begin
                    state_d = RB_HELD;
                    buf_d   = live_lo;
                end
            end
            RB_HELD: begin
                if (lo_rd)
                    state_d = RB_LIVE;
            end
            default: state_d = RB_LIVE;
        endcase
    end

    always_comb begin
        held    = (state_q == RB_HELD);
        buf_val = buf_q;
    end
endmodule

// File: rtl/frc_ovf.sv
module frc_ovf
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic stat_rd,
    input  logic main_acc,
    output logic flag
);
    ovf_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= OVF_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_IDLE: begin
                if (wrap)
                    state_d = OVF_PEND;
            end
            OVF_PEND: begin
                if (wrap)
                    state_d = OVF_PEND;
                else if (stat_rd)
                    state_d = OVF_ARMED;
            end
            OVF_ARMED: begin
                if (wrap)
                    state_d = OVF_PEND;
                else if (main_acc)
                    state_d = OVF_IDLE;
            end
            default: state_d = OVF_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q != OVF_IDLE);
    end
endmodule

// File: rtl/frc_timer.sv
module frc_timer
    import frc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRE_DIV = 4,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              stat_rd,
    input  logic              ovf_ie,
    output logic [7:0]        rd_data,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    logic             pre_tick;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_wrap;
    logic [15:0]      cnt_ext;
    logic             sel_main_hi, sel_main_lo, sel_alt_hi, sel_alt_lo;
    logic             hi_rd, lo_rd, main_acc;
    logic             buf_held;
    logic [7:0]       buf_val;

    frc_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (pre_tick)
    );

    frc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .step (pre_tick),
        .count(cnt_q),
        .wrap (cnt_wrap)
    );

    assign cnt_ext = 16'(cnt_q);

    assign sel_main_hi = rd_en && (rd_addr == ADDR_W'(ADR_MAIN_HI));
    assign sel_main_lo = rd_en && (rd_addr == ADDR_W'(ADR_MAIN_LO));
    assign sel_alt_hi  = rd_en && (rd_addr == ADDR_W'(ADR_ALT_HI));
    assign sel_alt_lo  = rd_en && (rd_addr == ADDR_W'(ADR_ALT_LO));

    assign hi_rd    = sel_main_hi || sel_alt_hi;
    assign lo_rd    = sel_main_lo || sel_alt_lo;
    assign main_acc = sel_main_hi || sel_main_lo;

    frc_rdbuf u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_rd  (hi_rd),
        .lo_rd  (lo_rd),
        .live_lo(cnt_ext[7:0]),
        .held   (buf_held),
        .buf_val(buf_val)
    );

    frc_ovf u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (cnt_wrap),
        .stat_rd (stat_rd),
        .main_acc(main_acc),
        .flag    (ovf_flag)
    );

    always_comb begin
        if (hi_rd)
            rd_data = cnt_ext[15:8];
        else if (lo_rd)
            rd_data = buf_held ? buf_val : cnt_ext[7:0];
        else
            rd_data = 8'h00;
    end

    assign ovf_irq = ovf_flag && ovf_ie;
endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             wrap,
    input logic             flag,
    input logic             irq,
    input logic             main_acc,
    input logic             held,
    input logic             lo_rd,
    input logic [7:0]       buf_val
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R1
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R7
    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R8
    AST_ALT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !main_acc) |=> flag); // R10
    AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !lo_rd) |=> (held && $stable(buf_val))); // R5
endmodule

bind frc_timer frc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (pre_tick),
    .cnt     (cnt_q),
    .wrap    (cnt_wrap),
    .flag    (ovf_flag),
    .irq     (ovf_irq),
    .main_acc(main_acc),
    .held    (buf_held),
    .lo_rd   (lo_rd),
    .buf_val (buf_val)
);

// File: tb/tb_frc_timer.sv
`timescale 1ns/1ps
module tb_frc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic       stat_rd = 1'b0;
    logic       ovf_ie = 1'b0;
    logic [7:0] rd_data, rd_data_w8;
    logic       ovf_flag, ovf_irq, ovf_flag_w8, ovf_irq_w8;

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;
    bit mheld  = 1'b0;
    logic [7:0] mbuf = 8'h00;

    always #4 clk = ~clk;
    always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

    frc_timer dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .stat_rd(stat_rd), .ovf_ie(ovf_ie), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    frc_timer #(.CNT_W(8)) dut_w8 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .stat_rd(stat_rd), .ovf_ie(ovf_ie), .rd_data(rd_data_w8),
        .ovf_flag(ovf_flag_w8), .ovf_irq(ovf_irq_w8)
    );

    // {requirement, idle gap, address}
    localparam int NVEC = 12;
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd4, 4'd0, 8'h19},   // R4 lone low read is live
        {4'd5, 4'd0, 8'h18},   // R5 high read captures low byte
        {4'd5, 4'd5, 8'h18},   // R5 repeat high read keeps buffer
        {4'd5, 4'd2, 8'h1A},   // R5 alternate high read keeps buffer
        {4'd6, 4'd3, 8'h19},   // R6 buffered low byte
        {4'd6, 4'd1, 8'h1B},   // R6 sequence ended, live again
        {4'd3, 4'd0, 8'h1A},   // R3 alternate high byte
        {4'd6, 4'd6, 8'h19},   // R6 buffer shared across pairs
        {4'd3, 4'd2, 8'h33},   // R3 unmapped address reads zero
        {4'd7, 4'd4, 8'h1B},   // R7 count unaffected by reads
        {4'd3, 4'd0, 8'h1B},   // R3 alternate low byte
        {4'd4, 4'd7, 8'h19}    // R4 live low after long gap
    };

    task automatic check(input bit ok, input int req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        logic [15:0] live;
        logic [7:0]  r;
        live = 16'hFFFC + 16'(ncyc / 4);
        if (a == 8'h18 || a == 8'h1A) begin
            r = live[15:8];
            if (!mheld) begin
                mheld = 1'b1;
                mbuf  = live[7:0];
            end
        end else if (a == 8'h19 || a == 8'h1B) begin
            r = mheld ? mbuf : live[7:0];
            mheld = 1'b0;
        end else begin
            r = 8'h00;
        end
        return r;
    endfunction

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] act, output logic [7:0] exp);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        #1;
        act = rd_data;
        exp = model_rd(a);
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic stat_pulse();
        @(negedge clk);
        stat_rd = 1'b1;
        @(posedge clk);
        #1 stat_rd = 1'b0;
    endtask

    task automatic wait_until(input int n);
        while (ncyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] act, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        #1;
        check(ovf_flag == 1'b0, 2, ovf_flag, 0);
        check(ovf_irq == 1'b0, 2, ovf_irq, 0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h1B; #1;
        check(rd_data == 8'hFC, 2, rd_data, 8'hFC);   // R2 reset count low byte
        rd_en = 1'b0;
        wait_until(3);
        rd_en = 1'b1; rd_addr = 8'h1B; #1;
        check(rd_data == 8'hFC, 2, rd_data, 8'hFC);   // R2 no step before 4th edge
        rd_en = 1'b0;
        wait_until(4);
        rd_en = 1'b1; rd_addr = 8'h1B; #1;
        check(rd_data == 8'hFD, 1, rd_data, 8'hFD);   // R1 first step
        rd_en = 1'b0;

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            repeat (int'(VEC[i][11:8])) @(negedge clk);
            bus_rd(VEC[i][7:0], act, exp);
            check(act == exp, int'(VEC[i][15:12]), act, exp);
        end

        // R8: flag set after first wrap (edge 16)
        wait_until(20);
        check(ovf_flag == 1'b1, 8, ovf_flag, 1);
        ovf_ie = 1'b1; #1;
        check(ovf_irq == 1'b1, 8, ovf_irq, 1);
        ovf_ie = 1'b0; #1;
        check(ovf_irq == 1'b0, 8, ovf_irq, 0);

        // R12: primary access without status read
        bus_rd(8'h18, act, exp);
        check(act == exp, 5, act, exp);
        bus_rd(8'h19, act, exp);
        check(act == exp, 6, act, exp);
        check(ovf_flag == 1'b1, 12, ovf_flag, 1);

        // R10: alternate reads after arming
        stat_pulse();
        bus_rd(8'h1A, act, exp);
        bus_rd(8'h1B, act, exp);
        check(act == exp, 6, act, exp);
        check(ovf_flag == 1'b1, 10, ovf_flag, 1);

        // R9: primary low read clears
        bus_rd(8'h19, act, exp);
        check(act == exp, 4, act, exp);
        check(ovf_flag == 1'b0, 9, ovf_flag, 0);
        check(ovf_flag_w8 == 1'b0, 9, ovf_flag_w8, 0);

        // R8 boundary on the 8-bit instance: second wrap on edge 1040
        wait_until(1039);
        check(ovf_flag_w8 == 1'b0, 8, ovf_flag_w8, 0);
        wait_until(1040);
        check(ovf_flag_w8 == 1'b1, 8, ovf_flag_w8, 1);

        // R11: wrap between arm and access keeps flag
        stat_pulse();
        wait_until(2070);
        bus_rd(8'h19, act, exp);
        check(ovf_flag_w8 == 1'b1, 11, ovf_flag_w8, 1);
        stat_pulse();
        bus_rd(8'h19, act, exp);
        check(ovf_flag_w8 == 1'b0, 9, ovf_flag_w8, 0);

        // R7: long run of reads, count still on schedule
        for (int k = 0; k < 20; k++) begin
            bus_rd(8'h18, act, exp);
        end
        bus_rd(8'h19, act, exp);
        check(act == exp, 7, act, exp);
        bus_rd(8'h19, act, exp);
        check(act == exp, 7, act, exp);
        check(ovf_flag == 1'b0, 8, ovf_flag, 0);

        finish_run();
    end
endmodule